// File: doc/BRIEF.md
# Multi-Mode Constellation Mapper

This block turns a serial stream of coded bits into complex baseband points for a downstream inverse FFT. A two-bit mode input selects one of four modulations: BPSK, QPSK, 16-QAM or 64-QAM. The block collects as many incoming bits as the active mode needs for one symbol, with the first bit received as the most significant. It then reads that mode's own lookup table and places the resulting fixed-point in-phase and quadrature pair on a valid/ready output stream.

The four tables have different depths: 2, 4, 16 and 64 entries. Each entry is 16 bits wide, with I in the upper byte and Q in the lower byte. Entry contents are computed at elaboration from Gray-coded amplitude levels and a per-mode scale parameter, so no table is typed in by hand. The mode select is taken into account only between symbols. Backpressure from the output stops the bit input, so no bit is lost.

Top module: `cmap_top`

## Requirements
- R1: Mode codes are 0 = BPSK, 1 = QPSK, 2 = 16-QAM and 3 = 64-QAM. A symbol takes 1, 2, 4 or 6 accepted bits in these modes, and the first accepted bit of a symbol is its most significant bit.
- R2: `iq_valid` is high in the cycle that follows the clock edge at which the last bit of a symbol is accepted.
- R3: In BPSK, bit 0 maps to I = -64 and bit 1 maps to I = +64. Q is 0.
- R4: In QPSK, the upper bit selects I and the lower bit selects Q. Bit value 0 gives -45 and bit value 1 gives +45.
- R5: In 16-QAM, the upper two bits select I and the lower two bits select Q. The codes 00, 01, 11 and 10 give -3, -1, +1 and +3 times 20.
- R6: In 64-QAM, the upper three bits select I and the lower three bits select Q. The codes 000, 001, 011, 010, 110, 111, 101 and 100 give -7, -5, -3, -1, +1, +3, +5 and +7 times 10.
- R7: `iq_i` and `iq_q` are 8-bit two's-complement values.
- R8: `mode_sel` is sampled only when a bit is accepted while no bits of a symbol are pending. A change of `mode_sel` in the middle of a symbol has no effect on that symbol.
- R9: While `iq_valid` is high and `iq_ready` is low, `bit_ready` is low and `iq_valid`, `iq_i` and `iq_q` hold their values. Every accepted symbol appears on the output exactly once, in order.
- R10: Synchronous active-low reset clears `iq_valid` and discards any partly collected symbol.
- R11: Idle cycles on `bit_valid`, inside a symbol or between symbols, do not change the grouping or the mapped values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Modulation select (R1 encoding) |
| bit_valid | input | 1 | Serial bit is offered |
| bit_data | input | 1 | Serial coded bit |
| bit_ready | output | 1 | Block can take a bit this cycle |
| iq_valid | output | 1 | Output pair is valid |
| iq_i | output | 8 | In-phase value, signed |
| iq_q | output | 8 | Quadrature value, signed |
| iq_ready | input | 1 | Downstream accepts the pair |

## Verification
The bench builds the block with its default parameters: 8-bit samples and scale factors 64, 45, 20 and 10. With these values every table entry of all four modes can be reached and predicted exactly. The largest 64-QAM level (±70) stays inside the 8-bit range. Each table is swept in full, and then mixed modes are run under random output stalls and input gaps. The bench also changes the mode in the middle of a symbol and asserts reset while a symbol is only partly collected.

// File: rtl/cmap_pkg.sv
// Package: shared mode encoding and helper functions for the constellation mapper.
// Assumes at most six bits per symbol (64-QAM).
package cmap_pkg;

    typedef enum logic [1:0] {
        MODE_BPSK  = 2'd0,
        MODE_QPSK  = 2'd1,
        MODE_QAM16 = 2'd2,
        MODE_QAM64 = 2'd3
    } cmap_mode_e;

    localparam int MAX_BITS = 6;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam int N_MODES  = 4;

    // Number of serial bits that form one symbol in a mode.
    function automatic int bits_of(logic [1:0] m);
        case (m)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 6;
        endcase
    endfunction

    // Odd amplitude level for a Gray-coded axis code of width m (0 when m is 0).
    function automatic int gray_level(int code, int m);
        int n;
        int prev;
        n    = 0;
        prev = 0;
        for (int b = m - 1; b >= 0; b--) begin
            prev = prev ^ ((code >> b) & 1);
            n    = (n << 1) | prev;
        end
        return 2 * n - ((1 << m) - 1);
    endfunction

endpackage

// File: rtl/cmap_grouper.sv
// Module: serial bit grouper.
// Shifts accepted bits in MSB-first and counts them against the bit count of the
// active mode. It pulses grp_fire with the full symbol address when the final bit
// is accepted. The mode is latched only at a symbol boundary.
// Assumes in_ready comes from the output stage and stays high whenever a pulse can be absorbed.
module cmap_grouper
    import cmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_sel,
    input  logic                bit_valid,
    input  logic                bit_data,
    input  logic                in_ready,
    output logic                grp_fire,
    output logic [MAX_BITS-1:0] grp_addr,
    output logic [1:0]          grp_mode
);

    logic [CNT_W-1:0]    cnt;
    logic [MAX_BITS-2:0] shreg;
    logic [1:0]          cur_mode;
    logic [1:0]          eff_mode;
    logic [CNT_W-1:0]    need;
    logic                accept;

    // Mode in force for this bit: a new select applies only with no bits pending.
    always_comb begin
        eff_mode = (cnt == '0) ? mode_sel : cur_mode;
        need     = CNT_W'(bits_of(eff_mode));
        accept   = bit_valid && in_ready;
        grp_fire = accept && ((cnt + 1'b1) == need);
        grp_addr = {shreg, bit_data};
        grp_mode = eff_mode;
    end

    // Bit count, shift register and mode latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            cur_mode <= MODE_BPSK;
        end else begin
            cur_mode <= eff_mode;
            if (accept) begin
                shreg <= {shreg[MAX_BITS-3:0], bit_data};
                cnt   <= grp_fire ? '0 : cnt + 1'b1;
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(bits_of(cur_mode)));                                   // R1
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cur_mode == $past(cur_mode)));                     // R8
    AST_STALL_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(cnt));                                        // R9

endmodule

// File: rtl/cmap_rom.sv
// Module: one mode's lookup table.
// Entry a holds {I, Q}. I comes from the upper ceil(ADDR_W/2) address bits and Q
// from the lower floor(ADDR_W/2) bits, each Gray-decoded to an odd level and
// multiplied by UNIT. Assumes UNIT*(2^ceil(ADDR_W/2)-1) fits in SAMPLE_W signed bits.
module cmap_rom
    import cmap_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int SAMPLE_W = 8,
    parameter int UNIT     = 45
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [2*SAMPLE_W-1:0] entry
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int Q_BITS = ADDR_W / 2;
    localparam int I_BITS = ADDR_W - Q_BITS;

    logic [2*SAMPLE_W-1:0] table_q [DEPTH];

    // Fill every entry from the Gray level rule at elaboration.
    for (genvar a = 0; a < DEPTH; a++) begin : g_ent
        localparam int LI = gray_level(a >> Q_BITS, I_BITS) * UNIT;
        localparam int LQ = gray_level(a & ((1 << Q_BITS) - 1), Q_BITS) * UNIT;
        localparam logic [31:0] VI = LI;
        localparam logic [31:0] VQ = LQ;
        assign table_q[a] = {VI[SAMPLE_W-1:0], VQ[SAMPLE_W-1:0]};
    end

    // Table read by symbol address.
    assign entry = table_q[addr];

endmodule

// File: rtl/cmap_ostage.sv
// Module: output register with valid/ready handshake.
// It captures the looked-up entry on a grouper pulse and holds the entry while
// the downstream stalls. It gives the input side a ready that never lets a pulse
// overwrite an unconsumed pair.
module cmap_ostage #(
    parameter int ENTRY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [ENTRY_W-1:0] entry,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [ENTRY_W-1:0] out_entry,
    output logic               in_ready
);

    // Room exists when empty or when the held pair leaves this cycle.
    assign in_ready = !out_valid || out_ready;

    // Load on a new symbol, clear once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_entry <= '0;
        end else if (fire) begin
            out_valid <= 1'b1;
            out_entry <= entry;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_entry)));   // R9
    AST_FIRE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid);                                                // R2
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> in_ready);                                                 // R9

endmodule

// File: rtl/cmap_top.sv
// Module: multi-mode constellation mapper top.
// Groups serial bits per mode, reads the table of the latched mode and presents
// {I, Q} on a valid/ready stream. Assumes the per-mode scale factors keep every
// level inside SAMPLE_W signed bits.
module cmap_top
    import cmap_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int UNIT_BPSK   = 64,
    parameter int UNIT_QPSK   = 45,
    parameter int UNIT_QAM16  = 20,
    parameter int UNIT_QAM64  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_sel,
    input  logic                bit_valid,
    input  logic                bit_data,
    output logic                bit_ready,
    output logic                iq_valid,
    output logic [SAMPLE_W-1:0] iq_i,
    output logic [SAMPLE_W-1:0] iq_q,
    input  logic                iq_ready
);

    localparam int ENTRY_W = 2 * SAMPLE_W;
    localparam int UNITS [N_MODES] = '{UNIT_BPSK, UNIT_QPSK, UNIT_QAM16, UNIT_QAM64};

    logic                grp_fire;
    logic [MAX_BITS-1:0] grp_addr;
    logic [1:0]          grp_mode;
    logic                in_ready;
    logic [ENTRY_W-1:0]  entries [N_MODES];
    logic [ENTRY_W-1:0]  sel_entry;
    logic [ENTRY_W-1:0]  out_entry;

    cmap_grouper u_grouper (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .in_ready  (in_ready),
        .grp_fire  (grp_fire),
        .grp_addr  (grp_addr),
        .grp_mode  (grp_mode)
    );

    // One table per mode, each addressed by that mode's symbol width.
    for (genvar m = 0; m < N_MODES; m++) begin : g_rom
        localparam int AW = bits_of(m[1:0]);
        cmap_rom #(
            .ADDR_W   (AW),
            .SAMPLE_W (SAMPLE_W),
            .UNIT     (UNITS[m])
        ) u_rom (
            .addr  (grp_addr[AW-1:0]),
            .entry (entries[m])
        );
    end

    // Pick the table of the mode that formed this symbol.
    assign sel_entry = entries[grp_mode];

    cmap_ostage #(
        .ENTRY_W (ENTRY_W)
    ) u_ostage (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (grp_fire),
        .entry     (sel_entry),
        .out_ready (iq_ready),
        .out_valid (iq_valid),
        .out_entry (out_entry),
        .in_ready  (in_ready)
    );

    // Split the held entry into its signed fields (R7).
    assign iq_i      = out_entry[ENTRY_W-1:SAMPLE_W];
    assign iq_q      = out_entry[SAMPLE_W-1:0];
    assign bit_ready = in_ready;

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> !iq_valid);                                              // R10

endmodule

// File: tb/cmap_top_bench.sv
// Scoreboard bench: a driver task pushes expected pairs, a monitor pops on each transfer.
module cmap_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       bit_valid = 1'b0;
    logic       bit_data = 1'b0;
    logic       bit_ready;
    logic       iq_valid;
    logic [7:0] iq_i;
    logic [7:0] iq_q;
    logic       iq_ready = 1'b1;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [7:0] i;
        logic [7:0] q;
        string      tag;
    } exp_t;
    exp_t sb[$];

    bit   stall_en = 1'b0;
    bit   gap_en = 1'b0;
    bit   last_acc = 1'b0;
    bit   pend = 1'b0;
    bit   held = 1'b0;
    logic [7:0] hi, hq;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] gsr = 16'h1D2B;

    cmap_top u_cmap_top (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bit_valid(bit_valid),
        .bit_data(bit_data), .bit_ready(bit_ready), .iq_valid(iq_valid),
        .iq_i(iq_i), .iq_q(iq_q), .iq_ready(iq_ready)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Axis level from the Gray tables in R3..R6.
    function automatic int lvl(int code, int m);
        case (m)
            0: return 0;
            1: return code ? 1 : -1;
            2: case (code) 0: return -3; 1: return -1; 3: return 1; default: return 3; endcase
            default: case (code)
                0: return -7; 1: return -5; 3: return -3; 2: return -1;
                6: return 1;  7: return 3;  5: return 5;  default: return 7;
            endcase
        endcase
    endfunction

    function automatic int nbits(int mode);
        case (mode) 0: return 1; 1: return 2; 2: return 4; default: return 6; endcase
    endfunction

    function automatic int unit_of(int mode);
        case (mode) 0: return 64; 1: return 45; 2: return 20; default: return 10; endcase
    endfunction

    // Drive bits MSB first; mode_sel shows 'mode' on the first bit and 'alt' afterwards.
    task automatic drive_bits(input int mode, input int alt, input int value, input int nb, input bit mark_last);
        for (int k = nb - 1; k >= 0; k--) begin
            @(negedge clk);
            while (gap_en && gsr[0]) begin
                bit_valid = 1'b0;
                @(negedge clk);
            end
            mode_sel  = (k == nb - 1) ? mode[1:0] : alt[1:0];
            bit_valid = 1'b1;
            bit_data  = value[k];
            #5;
            while (!bit_ready) begin
                @(negedge clk);
                #5;
            end
            if (k == 0 && mark_last) last_acc = 1'b1;
        end
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_sym(input int mode, input int alt, input int value, input string tag);
        exp_t e;
        int nb, qb, ib;
        nb = nbits(mode);
        qb = nb / 2;
        ib = nb - qb;
        e.i = 8'(lvl(value >> qb, ib) * unit_of(mode));
        e.q = 8'(lvl(value & ((1 << qb) - 1), qb) * unit_of(mode));
        e.tag = tag;
        sb.push_back(e);
        drive_bits(mode, alt, value, nb, 1'b1);
    endtask

    // Stall and gap generators.
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        gsr  <= {gsr[14:0], gsr[15] ^ gsr[14] ^ gsr[12] ^ gsr[3]};
        iq_ready <= stall_en ? lfsr[3] : 1'b1;
    end

    // Monitor: compare transfers, check hold under stall.
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            if (held) begin
                chk(iq_valid && iq_i == hi && iq_q == hq, "R9 hold", {iq_i, iq_q}, {hi, hq});
            end
            held = 1'b0;
            if (iq_valid && !iq_ready) begin
                chk(!bit_ready, "R9 input stalled", bit_ready, 0);
                held = 1'b1;
                hi = iq_i;
                hq = iq_q;
            end
            if (iq_valid && iq_ready) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected pair", {iq_i, iq_q}, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(iq_i == e.i && iq_q == e.q, {e.tag, " R7 pair"},
                        {iq_i, iq_q}, {e.i, e.q});
                end
            end
        end
    end

    // Latency checker for R2.
    always @(negedge clk) begin
        #6;
        if (pend && rst_n) chk(iq_valid, "R2 latency", iq_valid, 1);
        pend = last_acc;
        last_acc = 1'b0;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk(!iq_valid, "R10 reset valid", iq_valid, 0);
        chk(bit_ready, "R10 reset ready", bit_ready, 1);

        // Full sweeps, back to back.
        for (int v = 0; v < 2; v++)  send_sym(0, 0, v, "R3 R1");
        for (int v = 0; v < 4; v++)  send_sym(1, 1, v, "R4 R1");
        for (int v = 0; v < 16; v++) send_sym(2, 2, v, "R5 R1");
        for (int v = 0; v < 64; v++) send_sym(3, 3, v, "R6 R1");
        drain();

        // Mixed modes with stalls and gaps.
        stall_en = 1'b1;
        gap_en = 1'b1;
        for (int n = 0; n < 80; n++) begin
            int md;
            md = (n * 7 + 3) % 4;
            send_sym(md, md, (n * 37 + 11) % (1 << nbits(md)), "R9 R11");
        end
        drain();
        stall_en = 1'b0;
        gap_en = 1'b0;

        // Mode change inside a symbol is ignored.
        send_sym(2, 0, 4'b1001, "R8 qam16");
        send_sym(3, 1, 6'b101110, "R8 qam64");
        send_sym(1, 3, 2'b10, "R8 qpsk");
        drain();

        // Reset in the middle of a symbol discards the partial bits.
        drive_bits(3, 3, 6'b110000, 3, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk(!iq_valid, "R10 after reset", iq_valid, 0);
        send_sym(1, 1, 2'b01, "R10 clean start");
        send_sym(0, 0, 1, "R10 bpsk");
        drain();

        chk(sb.size() == 0, "R9 all delivered", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule